// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port Memory Channel

This block is a single-clock memory channel with one write port and one read port. Each has its own address and an active-low enable. Every 64-bit data word is stored as a 72-bit codeword that carries single-error-correct, double-error-detect check bits. The read port returns the decoded word one cycle after a read is accepted. Two flags report whether an error was found and whether it was corrected. Corrected data goes only to the read port and is never written back.

The storage is made of `BANKS` enabled banks of `BANK_WORDS` words each. The address width is sized for `MAX_BANKS` banks. Writes above the enabled range are dropped, and reads there return a meaningless value.

Two run-time controls support test and fault injection:
- Encoder bypass stores check bits supplied by the caller.
- Decoder bypass returns the stored codeword unchecked.

An active-low shutdown input wipes all stored contents.

Top module: `ecc_mem_channel`

## Requirements
- R1: With encoder and decoder both active, a word written with `wr_en_n` low and later read with `rd_en_n` low returns the same 64 bits on `rd_data[63:0]`, with `rd_data[71:64]` equal to zero and both flags low.
- R2: Check bits are computed from the data. Data bit i (i = 0..63) takes the (i+1)-th position in 3..71 that is not a power of two. Stored bit 64+k (k = 0..6) is the XOR of the data bits whose position has bit k set. Stored bit 71 makes the XOR of all 72 bits zero.
- R3: When `dec_bypass` is high on an accepted read, `rd_data` is the full stored 72-bit codeword and both flags stay low.
- R4: When `enc_bypass` is high on a write, `wr_data[71:0]` is stored as is. When it is low, bits [71:64] are generated per R2 and the upper bits of `wr_data` are ignored.
- R5: A codeword with exactly one flipped bit (data, check or overall parity) reads back with corrected data, `err_detect` high and `err_correct` high.
- R6: A codeword with exactly two flipped bits reads back with `err_detect` high and `err_correct` low.
- R7: Correction never changes the stored word. A later raw read still returns the erroneous codeword.
- R8: A write to an address at or above `BANKS*BANK_WORDS` changes no stored word.
- R9: A read and a write to the same address in the same cycle return the contents from before the write.
- R10: Read outputs change only one cycle after an accepted read. They hold while `rd_en_n` is high, and reset drives them to zero.
- R11: While `sd_n` is low, all storage is cleared to zero, writes are ignored, and accepted reads return zero with both flags low. After release, every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of read outputs |
| sd_n | input | 1 | Active-low shutdown; clears storage |
| wr_en_n | input | 1 | Active-low write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 72 | Write data; [71:64] used only under encoder bypass |
| enc_bypass | input | 1 | Store wr_data[71:64] as check bits |
| rd_en_n | input | 1 | Active-low read enable |
| rd_addr | input | ADDR_W | Read address |
| dec_bypass | input | 1 | Return raw codeword without checking |
| rd_data | output | 72 | Read data (decoded or raw) |
| err_detect | output | 1 | An error was found in the last read codeword |
| err_correct | output | 1 | The error was single-bit and was corrected |

## Verification
The assertions assume that `sd_n` and both bypass controls are known whenever a read is accepted. They also assume that reset is applied before the first read, so that the hold and bypass properties have a defined prior state. The stimulus drives every input to a defined value from time zero and changes inputs only on the falling clock edge. Reads of words that were never written are made only after a shutdown has cleared the storage.

// File: rtl/ecc_mem_channel.sv
module ecc_mem_channel #(
  parameter int BANKS      = 3,
  parameter int MAX_BANKS  = 4,
  parameter int BANK_WORDS = 16,
  localparam int DEPTH  = BANKS * BANK_WORDS,
  localparam int ADDR_W = $clog2(MAX_BANKS * BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [71:0]       wr_data,
  input  logic              enc_bypass,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              dec_bypass,
  output logic [71:0]       rd_data,
  output logic              err_detect,
  output logic              err_correct
);

  function automatic logic [6:0] hamming_check(input logic [63:0] d);
    logic [6:0] c;
    logic [7:0] pos;
    c = '0;
    pos = 8'd2;
    for (int i = 0; i < 64; i++) begin
      pos = pos + 8'd1;
      if ((pos & (pos - 8'd1)) == 8'd0) pos = pos + 8'd1;
      if (d[i]) c = c ^ pos[6:0];
    end
    return c;
  endfunction

  function automatic logic [63:0] flip_mask(input logic [6:0] syn);
    logic [63:0] m;
    logic [7:0]  pos;
    m = '0;
    pos = 8'd2;
    for (int i = 0; i < 64; i++) begin
      pos = pos + 8'd1;
      if ((pos & (pos - 8'd1)) == 8'd0) pos = pos + 8'd1;
      m[i] = (pos[6:0] == syn);
    end
    return m;
  endfunction

  logic [71:0] mem [DEPTH];

  logic        wr_ok, rd_ok;
  logic [6:0]  wr_chk;
  logic [71:0] wr_word, raw;
  logic [6:0]  syn;
  logic        par_odd;
  logic [63:0] fixed;

  assign wr_ok   = 32'(wr_addr) < DEPTH;
  assign rd_ok   = 32'(rd_addr) < DEPTH;
  assign wr_chk  = hamming_check(wr_data[63:0]);
  assign wr_word = enc_bypass ? wr_data
                              : {^{wr_chk, wr_data[63:0]}, wr_chk, wr_data[63:0]};

  always_ff @(posedge clk) begin
    if (!sd_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (!wr_en_n && wr_ok) begin
      mem[wr_addr] <= wr_word;
    end
  end

  assign raw     = rd_ok ? mem[rd_addr] : '0;
  assign syn     = raw[70:64] ^ hamming_check(raw[63:0]);
  assign par_odd = ^raw;
  assign fixed   = raw[63:0] ^ (par_odd ? flip_mask(syn) : 64'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      err_detect  <= 1'b0;
      err_correct <= 1'b0;
    end else if (!rd_en_n) begin
      if (!sd_n) begin
        rd_data     <= '0;
        err_detect  <= 1'b0;
        err_correct <= 1'b0;
      end else if (dec_bypass) begin
        rd_data     <= raw;
        err_detect  <= 1'b0;
        err_correct <= 1'b0;
      end else begin
        rd_data     <= {8'h00, fixed};
        err_detect  <= par_odd | (syn != 7'd0);
        err_correct <= par_odd;
      end
    end
  end

endmodule

module ecc_mem_channel_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_n,
  input logic              rd_en_n,
  input logic              dec_bypass,
  input logic [71:0]       rd_data,
  input logic              err_detect,
  input logic              err_correct
);

  assert_decoded_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && !dec_bypass) |=> rd_data[71:64] == 8'h00);

  assert_bypass_no_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && dec_bypass) |=> (!err_detect && !err_correct));

  assert_correct_implies_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_correct |-> err_detect);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> ($stable(rd_data) && $stable(err_detect) && $stable(err_correct)));

  assert_shutdown_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && !sd_n) |=> (rd_data == 72'd0 && !err_detect && !err_correct));

endmodule

bind ecc_mem_channel ecc_mem_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_n(sd_n), .rd_en_n(rd_en_n), .dec_bypass(dec_bypass),
  .rd_data(rd_data), .err_detect(err_detect), .err_correct(err_correct)
);

// File: tb/tb_ecc_mem_channel.sv
module tb_ecc_mem_channel;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, sd_n = 1;
  logic wr_en_n = 1, rd_en_n = 1, enc_bypass = 0, dec_bypass = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [71:0] wr_data = '0;
  logic [71:0] rd_data;
  logic err_detect, err_correct;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ecc_mem_channel dut (
    .clk(clk), .rst_n(rst_n), .sd_n(sd_n), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .enc_bypass(enc_bypass), .rd_en_n(rd_en_n), .rd_addr(rd_addr),
    .dec_bypass(dec_bypass), .rd_data(rd_data), .err_detect(err_detect),
    .err_correct(err_correct)
  );

  function automatic logic [71:0] encode(input logic [63:0] d);
    logic [6:0] c = '0;
    int pos = 2;
    for (int i = 0; i < 64; i++) begin
      pos++;
      if ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 7; k++) if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    end
    return {^{c, d}, c, d};
  endfunction

  task automatic chk(input string req, input logic [73:0] act, input logic [73:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [71:0] d, input logic byp);
    wr_en_n = 0; wr_addr = a; wr_data = d; enc_bypass = byp;
    @(negedge clk);
    wr_en_n = 1; enc_bypass = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic byp);
    rd_en_n = 0; rd_addr = a; dec_bypass = byp;
    @(negedge clk);
    rd_en_n = 1; dec_bypass = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset", {err_detect, err_correct, rd_data}, 74'd0);
  endtask

  task automatic t_basic();
    logic [63:0] d = 64'h0123_4567_89ab_cdef;
    wr(5, {8'hff, d}, 0);
    rd(5, 0);
    chk("R1 decoded read", {err_detect, err_correct, rd_data}, {2'b00, 8'h00, d});
    rd(5, 1);
    chk("R2 R4 generated check bits", {err_detect, err_correct, rd_data}, {2'b00, encode(d)});
    wr(6, 72'h0, 0);
    rd(6, 1);
    chk("R2 zero codeword", {2'b00, rd_data}, {2'b00, encode(64'd0)});
  endtask

  task automatic t_single();
    logic [63:0] d = 64'hdead_beef_cafe_f00d;
    logic [71:0] cw = encode(d);
    wr(10, cw ^ (72'd1 << 17), 1);
    rd(10, 0);
    chk("R5 data bit", {err_detect, err_correct, rd_data}, {2'b11, 8'h00, d});
    rd(10, 1);
    chk("R7 stored kept", {err_detect, err_correct, rd_data}, {2'b00, cw ^ (72'd1 << 17)});
    rd(10, 1);
    chk("R3 no flags on bypass", {err_detect, err_correct}, 74'd0);
    wr(11, cw ^ (72'd1 << 66), 1);
    rd(11, 0);
    chk("R5 check bit", {err_detect, err_correct, rd_data}, {2'b11, 8'h00, d});
    wr(12, cw ^ (72'd1 << 71), 1);
    rd(12, 0);
    chk("R5 parity bit", {err_detect, err_correct, rd_data}, {2'b11, 8'h00, d});
  endtask

  task automatic t_double();
    logic [71:0] cw = encode(64'h5555_aaaa_0f0f_f0f0);
    wr(13, cw ^ (72'd1 << 3) ^ (72'd1 << 40), 1);
    rd(13, 0);
    chk("R6 double error flags", {err_detect, err_correct}, {72'd0, 2'b10});
  endtask

  task automatic t_range();
    wr(48, encode(64'h1), 1);
    wr(63, encode(64'h2), 1);
    rd(5, 0);
    chk("R8 word 5 kept", {2'b00, rd_data}, {2'b00, 8'h00, 64'h0123_4567_89ab_cdef});
    rd(0, 1);
    chk("R8 word 0 kept", {2'b00, rd_data}, 74'd0);
    rd(47, 1);
    chk("R8 word 47 kept", {2'b00, rd_data}, 74'd0);
  endtask

  task automatic t_collide();
    wr(20, {8'h00, 64'h1111}, 0);
    wr_en_n = 0; wr_addr = 20; wr_data = {8'h00, 64'h2222};
    rd_en_n = 0; rd_addr = 20;
    @(negedge clk);
    wr_en_n = 1; rd_en_n = 1;
    chk("R9 old data", {2'b00, rd_data}, {2'b00, 8'h00, 64'h1111});
    rd(20, 0);
    chk("R9 new data stored", {2'b00, rd_data}, {2'b00, 8'h00, 64'h2222});
  endtask

  task automatic t_hold();
    rd(5, 0);
    rd_addr = 20; wr_en_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R10 hold", {err_detect, err_correct, rd_data}, {2'b00, 8'h00, 64'h0123_4567_89ab_cdef});
    wr_en_n = 1; wr_addr = 21; wr_data = {8'h00, 64'h77};
    @(negedge clk);
    rd(21, 1);
    chk("R1 disabled write", {2'b00, rd_data}, 74'd0);
  endtask

  task automatic t_shutdown();
    sd_n = 0;
    @(negedge clk);
    rd(5, 0);
    chk("R11 read in shutdown", {err_detect, err_correct, rd_data}, 74'd0);
    wr(7, {8'h00, 64'h99}, 0);
    sd_n = 1;
    @(negedge clk);
    rd(5, 1);
    chk("R11 cleared", {2'b00, rd_data}, 74'd0);
    rd(7, 1);
    chk("R11 write ignored", {2'b00, rd_data}, 74'd0);
    rd(10, 0);
    chk("R11 no stale error", {err_detect, err_correct, rd_data}, 74'd0);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sd_n = 0;
    @(negedge clk); @(negedge clk);
    sd_n = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_double();
    t_range();
    t_collide();
    t_hold();
    t_shutdown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule